// File: doc/BRIEF.md
# Transmit FIFO Start and Pad Controller

This block sits between the transmit FIFO of an Ethernet MAC and its transmitter. It decides when to ask the system bus for more frame data, and when to launch the current frame. A frame is launched once enough of its bytes are in the FIFO, or once the whole frame is there, whichever happens first. It also fixes the framing options for each frame: whether pad bytes are inserted and whether the 4-byte FCS is appended.

The frame options are sampled on the cycle the frame is launched and then held for the rest of that frame. When global auto-pad is on, it forces FCS append, so the per-frame FCS-disable request has no effect. When auto-pad is off, frames shorter than the minimum go out unpadded, and the FCS-disable flag is honoured for each frame separately. When the last byte is handed to the transmitter, the block reports how many pad bytes are needed to bring data plus FCS up to 64 bytes.

Top module: `txf_ctrl`

## Requirements
- R1: One cycle after each cycle, `bus_req` is 1 exactly when `DEPTH - fifo_level` is at least the watermark. The watermark is `WM_BASE << wm_sel`, which gives 8, 16, 32 or 64 free bytes at the default parameters.
- R2: `tx_start` is 1 in the cycle after a cycle that meets all of these conditions: the frame has not started, `last_byte_out` is 0, and the frame's byte count before that cycle's write is at least `SP_BASE << sp_sel` (4, 8, 16 or 32 by default).
- R3: In a cycle where the frame has not started and `last_byte_out` is 0, a high `eof_in_fifo` launches the frame on the next cycle, even when the start threshold is not met.
- R4: `tx_start` is a one-cycle pulse and fires at most once per frame. The frame counts as started from that pulse until `last_byte_out`.
- R5: If `auto_pad` is 1 in the launch cycle, then `pad_en` becomes 1 and `fcs_en` becomes 1, whatever the value of `fcs_dis`.
- R6: If `auto_pad` is 0 in the launch cycle, then `pad_en` becomes 0 and `fcs_en` becomes the inverse of `fcs_dis`. Runt frames are therefore sent unpadded.
- R7: `pad_en` and `fcs_en` change only on a launch. Changes to `auto_pad` or `fcs_dis` between launches have no effect on them.
- R8: On the cycle after `last_byte_out`, `pad_len` equals `60 - count` when `pad_en` is 1 and the count is below 60. Otherwise it equals 0. It holds that value until the next `last_byte_out`.
- R9: `last_byte_out` clears the frame byte count. A `byte_wr` in the same cycle counts as the first byte of the next frame.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | LVL_W | Bytes currently held in the transmit FIFO |
| wm_sel | input | 2 | Selects the free-space watermark |
| sp_sel | input | 2 | Selects the start threshold |
| byte_wr | input | 1 | One byte of the current frame was written to the FIFO |
| eof_in_fifo | input | 1 | The whole current frame is in the FIFO |
| last_byte_out | input | 1 | The frame's last byte was handed to the transmitter |
| auto_pad | input | 1 | Global auto-pad enable |
| fcs_dis | input | 1 | Per-frame request to omit the FCS |
| bus_req | output | 1 | Request for more transmit data |
| tx_start | output | 1 | One-cycle frame launch pulse |
| pad_en | output | 1 | Pad insertion active for the launched frame |
| fcs_en | output | 1 | FCS append active for the launched frame |
| pad_len | output | CNT_W | Pad bytes needed by the frame just finished |

## Verification
The assertions assume the following about the inputs:
- `fifo_level` never exceeds `DEPTH`.
- `last_byte_out` arrives only after the frame has been launched.
- `eof_in_fifo` drops in the same cycle as `last_byte_out`, so it never stays high into the next frame.

The stimulus builds each frame in order (writes, then the end flag, then the launch, then the last byte), and draws the FIFO level only within 0 to `DEPTH`. Within that order it randomizes write gaps, frame lengths, selector values and the option flags. Some option flags are toggled after launch, to show that the latched values do not change.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Threshold for a 2-bit selector: base, 2x, 4x or 8x.
  function automatic int unsigned level_thr(int unsigned base, logic [1:0] sel);
    return base << sel;
  endfunction

  // Pad bytes needed so that data length reaches min_data.
  function automatic int unsigned pad_fill(int unsigned len, int unsigned min_data);
    return (len >= min_data) ? 0 : (min_data - len);
  endfunction

endpackage

// File: rtl/txf_req_gen.sv
module txf_req_gen
  import txf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int WM_BASE = 8,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       wm_sel,
  output logic             bus_req
);

  logic [LVL_W-1:0] free_space;
  logic             room_ok;

  assign free_space = LVL_W'(DEPTH) - fifo_level;
  assign room_ok    = int'(free_space) >= int'(level_thr(WM_BASE, wm_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_req <= 1'b0;
    else        bus_req <= room_ok;
  end

  // R1
  req_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $past(room_ok));

endmodule

// File: rtl/txf_start_ctl.sv
module txf_start_ctl
  import txf_pkg::*;
#(
  parameter int SP_BASE = 4,
  parameter int CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sp_sel,
  input  logic             byte_wr,
  input  logic             eof_in_fifo,
  input  logic             last_byte_out,
  output logic             start_go,
  output logic             tx_start,
  output logic [CNT_W-1:0] frame_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic started;
  logic thr_hit;

  assign thr_hit  = int'(frame_cnt) >= int'(level_thr(SP_BASE, sp_sel));
  assign start_go = !started && !last_byte_out && (thr_hit || eof_in_fifo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      started   <= 1'b0;
      tx_start  <= 1'b0;
    end else begin
      tx_start <= start_go;
      if (last_byte_out)  started <= 1'b0;
      else if (start_go)  started <= 1'b1;
      if (last_byte_out)
        frame_cnt <= byte_wr ? CNT_W'(1) : '0;
      else if (byte_wr && frame_cnt != CNT_MAX)
        frame_cnt <= frame_cnt + 1'b1;
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R2 R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(thr_hit || eof_in_fifo));

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> started);

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(last_byte_out)) |-> (frame_cnt <= CNT_W'(1)));

endmodule

// File: rtl/txf_opt_sel.sv
module txf_opt_sel
  import txf_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int MIN_FRAME = 64,
  parameter int FCS_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             auto_pad,
  input  logic             fcs_dis,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] frame_len,
  output logic             pad_en,
  output logic             fcs_en,
  output logic [CNT_W-1:0] pad_len
);

  localparam int MIN_DATA = MIN_FRAME - FCS_BYTES;

  logic             fcs_sel;
  logic [CNT_W-1:0] pad_calc;

  assign fcs_sel  = auto_pad | ~fcs_dis;
  assign pad_calc = CNT_W'(pad_fill(int'(frame_len), MIN_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_en  <= 1'b0;
      fcs_en  <= 1'b0;
      pad_len <= '0;
    end else begin
      if (load) begin
        pad_en <= auto_pad;
        fcs_en <= fcs_sel;
      end
      if (frame_done)
        pad_len <= pad_en ? pad_calc : '0;
    end
  end

  // R5
  pad_forces_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_en |-> fcs_en);

  // R7
  opt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load)) |-> ($stable(pad_en) && $stable(fcs_en)));

  // R8
  pad_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pad_len) <= MIN_DATA);

  // R8
  nopad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(frame_done) && !$past(pad_en)) |-> (pad_len == '0));

endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
  parameter int DEPTH     = 64,
  parameter int WM_BASE   = 8,
  parameter int SP_BASE   = 4,
  parameter int MAX_FRAME = 1536,
  parameter int MIN_FRAME = 64,
  parameter int FCS_BYTES = 4,
  parameter int LVL_W     = $clog2(DEPTH + 1),
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       wm_sel,
  input  logic [1:0]       sp_sel,
  input  logic             byte_wr,
  input  logic             eof_in_fifo,
  input  logic             last_byte_out,
  input  logic             auto_pad,
  input  logic             fcs_dis,
  output logic             bus_req,
  output logic             tx_start,
  output logic             pad_en,
  output logic             fcs_en,
  output logic [CNT_W-1:0] pad_len
);

  logic             start_go;
  logic [CNT_W-1:0] frame_cnt;

  txf_req_gen #(.DEPTH(DEPTH), .WM_BASE(WM_BASE), .LVL_W(LVL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .wm_sel(wm_sel),
    .bus_req(bus_req)
  );

  txf_start_ctl #(.SP_BASE(SP_BASE), .CNT_W(CNT_W)) u_start (
    .clk(clk), .rst_n(rst_n), .sp_sel(sp_sel), .byte_wr(byte_wr),
    .eof_in_fifo(eof_in_fifo), .last_byte_out(last_byte_out),
    .start_go(start_go), .tx_start(tx_start), .frame_cnt(frame_cnt)
  );

  txf_opt_sel #(.CNT_W(CNT_W), .MIN_FRAME(MIN_FRAME), .FCS_BYTES(FCS_BYTES)) u_opt (
    .clk(clk), .rst_n(rst_n), .load(start_go), .auto_pad(auto_pad),
    .fcs_dis(fcs_dis), .frame_done(last_byte_out), .frame_len(frame_cnt),
    .pad_en(pad_en), .fcs_en(fcs_en), .pad_len(pad_len)
  );

  // R4 R6
  start_loads_opts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !pad_en) |-> (fcs_en == !$past(fcs_dis)));

endmodule

// File: tb/txf_ctrl_bench.sv
module txf_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  fifo_level = '0;
  logic [1:0]  wm_sel = '0, sp_sel = '0;
  logic        byte_wr = 0, eof_in_fifo = 0, last_byte_out = 0;
  logic        auto_pad = 0, fcs_dis = 0;
  logic        bus_req, tx_start, pad_en, fcs_en;
  logic [10:0] pad_len;

  always #5 clk = ~clk;

  txf_ctrl u_txf_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .wm_sel(wm_sel),
    .sp_sel(sp_sel), .byte_wr(byte_wr), .eof_in_fifo(eof_in_fifo),
    .last_byte_out(last_byte_out), .auto_pad(auto_pad), .fcs_dis(fcs_dis),
    .bus_req(bus_req), .tx_start(tx_start), .pad_en(pad_en),
    .fcs_en(fcs_en), .pad_len(pad_len)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_cnt = 0, m_padlen = 0;
  bit m_st = 0, m_start = 0, m_req = 0, m_pad = 0, m_fcs = 0;

  function automatic int wm_of(logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 16; 2'd2: return 32; default: return 64; endcase
  endfunction
  function automatic int sp_of(logic [1:0] s);
    case (s) 2'd0: return 4; 2'd1: return 8; 2'd2: return 16; default: return 32; endcase
  endfunction
  function automatic int pad_of(int len);
    if (len < 60) return 60 - len;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    bit go;
    @(posedge clk);
    go = !m_st && !last_byte_out && (m_cnt >= sp_of(sp_sel) || eof_in_fifo);
    if (last_byte_out) m_padlen = m_pad ? pad_of(m_cnt) : 0;
    if (go) begin m_pad = auto_pad; m_fcs = auto_pad || !fcs_dis; end
    m_start = go;
    m_req = (64 - int'(fifo_level)) >= wm_of(wm_sel);
    if (last_byte_out) m_st = 0; else if (go) m_st = 1;
    if (last_byte_out) m_cnt = byte_wr ? 1 : 0;
    else if (byte_wr && m_cnt < 2047) m_cnt++;
    @(negedge clk);
    chk("R1 bus_req", bus_req, m_req);
    chk("R2 R3 R4 tx_start", tx_start, m_start);
    chk("R5 R6 R7 pad_en", pad_en, m_pad);
    chk("R5 R6 R7 fcs_en", fcs_en, m_fcs);
    chk("R8 pad_len", pad_len, m_padlen);
  endtask

  task automatic end_frame();
    eof_in_fifo = 0; last_byte_out = 1; cyc();
    last_byte_out = 0; cyc();
  endtask

  task automatic run_frame(int len, bit ap, bit fd, logic [1:0] sps, bit rnd);
    int n = 0;
    int guard = 0;
    sp_sel = sps; auto_pad = ap; fcs_dis = fd;
    while (n < len) begin
      byte_wr = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
      if (byte_wr) n++;
      if (rnd) begin fifo_level = 7'($urandom_range(0, 64)); wm_sel = 2'($urandom); end
      cyc();
    end
    byte_wr = 0; eof_in_fifo = 1;
    while (!m_st && guard < 10) begin cyc(); guard++; end
    if (rnd) repeat ($urandom_range(0, 3)) begin
      auto_pad = 1'($urandom); fcs_dis = 1'($urandom); cyc();
    end
    end_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 bus_req", bus_req, 0);
    chk("R10 tx_start", tx_start, 0);
    chk("R10 pad_en", pad_en, 0);
    chk("R10 fcs_en", fcs_en, 0);
    chk("R10 pad_len", pad_len, 0);
    rst_n = 1;
    cyc();

    // R1 watermark boundary: 16 free bytes exactly, then one fewer
    wm_sel = 2'd1; fifo_level = 7'd48; cyc(); chk("R1 edge", bus_req, 1);
    fifo_level = 7'd49; cyc(); chk("R1 edge", bus_req, 0);
    fifo_level = 7'd0;

    // R3 short frame launched by end-of-frame, with auto-pad: R5 R8
    run_frame(10, 1, 1, 2'd3, 0);
    chk("R5 fcs forced", fcs_en, 1);
    chk("R8 pad for 10", pad_len, 50);
    // R2 long frame launched by threshold, runt rules R6
    run_frame(100, 0, 1, 2'd0, 0);
    chk("R6 fcs off", fcs_en, 0);
    chk("R8 no pad", pad_len, 0);
    run_frame(20, 0, 0, 2'd2, 0);
    chk("R6 runt unpadded", pad_len, 0);

    // R9 write in the clearing cycle counts for the next frame
    sp_sel = 2'd0; byte_wr = 1; eof_in_fifo = 1; cyc();
    eof_in_fifo = 0; last_byte_out = 1; cyc();
    last_byte_out = 0; cyc(); cyc(); cyc();
    chk("R9 not yet", tx_start, 0);
    byte_wr = 0; cyc();
    chk("R9 start at 4", tx_start, 1);
    eof_in_fifo = 1; cyc();
    end_frame();

    for (int i = 0; i < 150; i++)
      run_frame($urandom_range(1, 100), 1'($urandom), 1'($urandom), 2'($urandom), 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule